// File: doc/BRIEF.md
# Function Power State Access Gate

This block sits between a bus target interface and the register and interrupt logic of a controller function. It holds the function's power state, which is either full power (D0) or the low-power D3-hot state, and software changes it by writing a two-bit field in configuration space. The upstream decoder marks each incoming transaction with its address space. The gate forwards it to the register logic, or it completes the transaction itself as a master abort.

In D3-hot only configuration-space traffic gets through. Memory and I/O accesses are refused with a master abort. The interrupt line is held low whatever the status and enable bits say. The status bits stay where they are, in the register file outside this block. When software brings the function back to D0, any enabled status bit that is still set raises the interrupt again without further action.

Top module: `pm_access_gate`

## Requirements
- R1: After reset the power state reads 00 (D0), and `fwd_valid`, `abort_valid` and `irq_out` are all low.
- R2: A configuration write of 11 to the power field selects D3-hot, and a write of 00 selects D0. The new value appears on `pm_state` in the cycle after the write is accepted.
- R3: A write of the values 01 or 10 to the power field is ignored, and the field keeps its previous value in both D0 and D3-hot.
- R4: A transaction in configuration space (space code 00) is forwarded (`fwd_valid` high, `abort_valid` low) in both power states.
- R5: In D0, transactions in memory space (01), I/O space (10) and the unused space code 11 are forwarded, and none is aborted.
- R6: In D3-hot, a transaction with space code 01, 10 or 11 is not forwarded and is completed as a master abort (`abort_valid` high).
- R7: A transaction that arrives in the same cycle as a power-field write is judged by the state in force before that write.
- R8: In D0, `irq_out` is high one cycle after any bit position has both its status and its enable bit set, and low one cycle after no such position remains.
- R9: From the cycle after D3-hot takes effect, `irq_out` stays low even when enabled status bits are set.
- R10: If an enabled status bit is still set when the state returns to D0, `irq_out` goes high one cycle after `pm_state` shows 00.
- R11: A status bit whose enable bit is clear never raises `irq_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_pm_wr | input | 1 | Write strobe for the power-state field |
| cfg_pm_wdata | input | 2 | Value written to the power-state field |
| pm_state | output | 2 | Current power state (00 = D0, 11 = D3-hot) |
| req_valid | input | 1 | Incoming transaction valid |
| req_space | input | 2 | Address space of the transaction (00 config, 01 memory, 10 I/O, 11 unused) |
| fwd_valid | output | 1 | Transaction passed on to the register logic |
| abort_valid | output | 1 | Transaction completed as a master abort |
| irq_sts | input | N_IRQ | Interrupt status bits from the register file |
| irq_en | input | N_IRQ | Interrupt enable bits from the register file |
| irq_out | output | 1 | Interrupt request to the system |

## Verification
The forward and abort outputs are combinational over the registered power state. The bench drives each transaction just after a falling edge and reads these outputs one time unit later in the same low phase. A power-field write shows on `pm_state` at the next falling edge. The interrupt output is due one falling edge after the conditions that feed it settle. Returning to D0 therefore makes it rise two falling edges after the write was driven, and the bench checks that it is still low at the first of those edges.

// File: rtl/pm_gate_pkg.sv
package pm_gate_pkg;

   localparam int PS_W    = 2;
   localparam int SPACE_W = 2;

   typedef enum logic [PS_W-1:0] {
      PS_FULL  = 2'b00,
      PS_RSVA  = 2'b01,
      PS_RSVB  = 2'b10,
      PS_LOW   = 2'b11
   } pstate_e;

   typedef enum logic [SPACE_W-1:0] {
      SPC_CFG  = 2'b00,
      SPC_MEM  = 2'b01,
      SPC_IO   = 2'b10,
      SPC_UNU  = 2'b11
   } space_e;

endpackage

// File: rtl/pm_state_reg.sv
module pm_state_reg
   import pm_gate_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    wr_en,
   input  pstate_e wr_val,
   output pstate_e state
);

   logic legal;
   assign legal = (wr_val == PS_FULL) || (wr_val == PS_LOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= PS_FULL;
      else if (wr_en && legal)
         state <= wr_val;
   end

   // R2
   state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == PS_FULL) || (state == PS_LOW));

   // R3
   rsv_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_val == PS_RSVA || wr_val == PS_RSVB)) |=> $stable(state));

endmodule

// File: rtl/pm_txn_filter.sv
module pm_txn_filter
   import pm_gate_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  space_e req_space,
   input  logic   low_power,
   output logic   fwd_valid,
   output logic   abort_valid
);

   logic blocked;

   always_comb begin
      blocked     = low_power && (req_space != SPC_CFG);
      fwd_valid   = req_valid && !blocked;
      abort_valid = req_valid && blocked;
   end

   // R4
   cfg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_space == SPC_CFG) |-> (fwd_valid && !abort_valid));

   // R6
   low_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && low_power && req_space != SPC_CFG) |-> (abort_valid && !fwd_valid));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> !(fwd_valid || abort_valid));

endmodule

// File: rtl/pm_irq_mask.sv
module pm_irq_mask #(
   parameter int N_IRQ   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_IRQ-1:0] sts,
   input  logic [N_IRQ-1:0] en,
   input  logic             full_power,
   output logic             irq
);

   logic any_pend;
   assign any_pend = |(sts & en);

   generate
      if (REG_OUT) begin : g_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               irq_q <= 1'b0;
            else
               irq_q <= full_power && any_pend;
         end
         assign irq = irq_q;

         // R9
         low_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !full_power |=> !irq);

         // R10
         reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (full_power && any_pend) |=> irq);
      end else begin : g_comb
         assign irq = full_power && any_pend;

         // R9
         low_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !full_power |-> !irq);
      end
   endgenerate

   // R11
   masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sts & en) == '0) |=> ((sts & en) != '0) || !irq || !REG_OUT);

endmodule

// File: rtl/pm_access_gate.sv
module pm_access_gate
   import pm_gate_pkg::*;
#(
   parameter int N_IRQ   = 8,
   parameter bit REG_OUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_pm_wr,
   input  logic [1:0]       cfg_pm_wdata,
   output logic [1:0]       pm_state,
   input  logic             req_valid,
   input  logic [1:0]       req_space,
   output logic             fwd_valid,
   output logic             abort_valid,
   input  logic [N_IRQ-1:0] irq_sts,
   input  logic [N_IRQ-1:0] irq_en,
   output logic             irq_out
);

   generate
      if (N_IRQ < 1 || N_IRQ > 1024) begin : g_bad_n
         $fatal(1, "pm_access_gate: N_IRQ out of range");
      end
   endgenerate

   pstate_e cur_state;
   logic    in_low;

   pm_state_reg u_state (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_pm_wr),
      .wr_val (pstate_e'(cfg_pm_wdata)),
      .state  (cur_state)
   );

   assign in_low   = (cur_state == PS_LOW);
   assign pm_state = cur_state;

   pm_txn_filter u_filter (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid   (req_valid),
      .req_space   (space_e'(req_space)),
      .low_power   (in_low),
      .fwd_valid   (fwd_valid),
      .abort_valid (abort_valid)
   );

   pm_irq_mask #(
      .N_IRQ   (N_IRQ),
      .REG_OUT (REG_OUT)
   ) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sts        (irq_sts),
      .en         (irq_en),
      .full_power (!in_low),
      .irq        (irq_out)
   );

   // R7
   same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_pm_wr && req_valid && req_space != 2'b00 && pm_state == 2'b00) |-> fwd_valid);

endmodule

// File: tb/pm_access_gate_bench.sv
module pm_access_gate_bench;

   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cfg_pm_wr = 1'b0;
   logic [1:0]   cfg_pm_wdata = 2'b00;
   logic [1:0]   pm_state;
   logic         req_valid = 1'b0;
   logic [1:0]   req_space = 2'b00;
   logic         fwd_valid;
   logic         abort_valid;
   logic [N-1:0] irq_sts = '0;
   logic [N-1:0] irq_en = '0;
   logic         irq_out;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pm_access_gate #(.N_IRQ(N)) u_pm_access_gate (
      .clk          (clk),
      .rst_n        (rst_n),
      .cfg_pm_wr    (cfg_pm_wr),
      .cfg_pm_wdata (cfg_pm_wdata),
      .pm_state     (pm_state),
      .req_valid    (req_valid),
      .req_space    (req_space),
      .fwd_valid    (fwd_valid),
      .abort_valid  (abort_valid),
      .irq_sts      (irq_sts),
      .irq_en       (irq_en),
      .irq_out      (irq_out)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic write_pm(input logic [1:0] v);
      @(negedge clk);
      cfg_pm_wr    = 1'b1;
      cfg_pm_wdata = v;
      @(negedge clk);
      cfg_pm_wr    = 1'b0;
   endtask

   task automatic probe(input logic [1:0] sp, input bit exp_fwd, input string req);
      @(negedge clk);
      req_valid = 1'b1;
      req_space = sp;
      #1;
      check(fwd_valid == exp_fwd, {req, " fwd"}, fwd_valid, exp_fwd);
      check(abort_valid == !exp_fwd, {req, " abort"}, abort_valid, !exp_fwd);
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(pm_state == 2'b00, "R1 state", pm_state, 0);
      check(!fwd_valid && !abort_valid, "R1 txn outputs", {fwd_valid, abort_valid}, 0);
      check(irq_out == 1'b0, "R1 irq", irq_out, 0);
   endtask

   task automatic t_full_power_traffic;
      probe(2'b00, 1'b1, "R4 cfg in D0");
      probe(2'b01, 1'b1, "R5 mem in D0");
      probe(2'b10, 1'b1, "R5 io in D0");
      probe(2'b11, 1'b1, "R5 unused in D0");
   endtask

   task automatic t_irq_d0;
      @(negedge clk);
      irq_sts = 8'h05;
      irq_en  = 8'h02;
      @(negedge clk);
      check(irq_out == 1'b0, "R11 disabled status", irq_out, 0);
      irq_en = 8'h04;
      @(negedge clk);
      check(irq_out == 1'b1, "R8 enabled status", irq_out, 1);
   endtask

   task automatic t_enter_low;
      @(negedge clk);
      cfg_pm_wr    = 1'b1;
      cfg_pm_wdata = 2'b11;
      req_valid    = 1'b1;
      req_space    = 2'b01;
      #1;
      check(fwd_valid == 1'b1, "R7 old state used", fwd_valid, 1);
      @(negedge clk);
      cfg_pm_wr = 1'b0;
      req_valid = 1'b0;
      check(pm_state == 2'b11, "R2 enter D3", pm_state, 3);
      @(negedge clk);
      check(irq_out == 1'b0, "R9 masked in D3", irq_out, 0);
      repeat (3) @(negedge clk);
      check(irq_out == 1'b0, "R9 stays masked", irq_out, 0);
   endtask

   task automatic t_low_traffic;
      probe(2'b00, 1'b1, "R4 cfg in D3");
      probe(2'b01, 1'b0, "R6 mem in D3");
      probe(2'b10, 1'b0, "R6 io in D3");
      probe(2'b11, 1'b0, "R6 unused in D3");
   endtask

   task automatic t_rsv_in_low;
      write_pm(2'b01);
      check(pm_state == 2'b11, "R3 01 in D3", pm_state, 3);
      write_pm(2'b10);
      check(pm_state == 2'b11, "R3 10 in D3", pm_state, 3);
      probe(2'b01, 1'b0, "R3 still D3 mem");
   endtask

   task automatic t_return_full;
      @(negedge clk);
      cfg_pm_wr    = 1'b1;
      cfg_pm_wdata = 2'b00;
      @(negedge clk);
      cfg_pm_wr = 1'b0;
      check(pm_state == 2'b00, "R2 back to D0", pm_state, 0);
      check(irq_out == 1'b0, "R10 not yet", irq_out, 0);
      @(negedge clk);
      check(irq_out == 1'b1, "R10 reissued", irq_out, 1);
   endtask

   task automatic t_rsv_in_full;
      write_pm(2'b10);
      check(pm_state == 2'b00, "R3 10 in D0", pm_state, 0);
      probe(2'b10, 1'b1, "R3 still D0 io");
   endtask

   task automatic t_clear;
      @(negedge clk);
      irq_sts = '0;
      @(negedge clk);
      check(irq_out == 1'b0, "R8 cleared", irq_out, 0);
      irq_sts = 8'h80;
      irq_en  = 8'h80;
      @(negedge clk);
      check(irq_out == 1'b1, "R8 top bit", irq_out, 1);
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full_power_traffic();
      t_irq_d0();
      t_enter_low();
      t_low_traffic();
      t_rsv_in_low();
      t_return_full();
      t_rsv_in_full();
      t_clear();
      repeat (2) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule